// File: doc/BRIEF.md
# Selectable-Polynomial Reflected CRC Accumulator

This block keeps a 32-bit running checksum and folds one data beat into it per clock when the beat is qualified by a valid strobe. A beat is 8, 16 or 32 bits wide, as chosen by a width select. Within a beat, bits enter the checksum least significant bit first. For wider beats, the lanes are taken in ascending byte order. A two-bit select picks one of three generator polynomials, 0x04C11DB7, 0x1EDC6F41 or 0x1021, at run time. The register shifts toward its most significant end, and no final inversion is applied.

The checksum starts at all ones after reset and returns to all ones on a one-cycle clear command. Without a clear, the value carries over from one transfer to the next. A checksum over several separate regions is therefore built by feeding the regions one after another. For the 0x04C11DB7 choice, the value read out equals the usual table-driven CRC-32 of the same bytes after reversing all 32 bits and inverting them. A producer that emits data most significant bit first must mirror each byte before feeding it in.

Top module: `crc_accum`

## Requirements
- R1: After synchronous reset, and in the cycle after `crc_clear` is high, `crc_value` reads 0xFFFFFFFF.
- R2: With `poly_sel` = 0, each data bit d, taken LSB first, updates the register as fb = crc[31]^d, crc = (crc<<1) ^ (fb ? 0x04C11DB7 : 0). After the nine bytes "123456789" from a cleared state, the value is the 32-bit reversal of 0xCBF43926, inverted.
- R3: With `poly_sel` = 1, the same rule applies with 0x1EDC6F41. The value for "123456789" is the 32-bit reversal of 0xE3069283, inverted.
- R4: With `poly_sel` = 2, only bits [15:0] update, as fb = crc[15]^d, crc[15:0] = (crc[15:0]<<1) ^ (fb ? 0x1021 : 0), while bits [31:16] keep their value. For "123456789" from a cleared state, the low half is the 16-bit reversal of 0x6F91.
- R5: `poly_sel` = 3 gives the same result as `poly_sel` = 0.
- R6: `beat_width` 0 consumes `beat_data[7:0]`, 1 consumes `[15:0]`, and 2 or 3 consume all 32 bits. The unused upper lanes have no effect. Lanes are taken in ascending byte order, so one word beat equals four byte beats of its bytes, lowest byte first.
- R7: While `beat_valid` and `crc_clear` are both low, `crc_value` holds, whatever the data, width and polynomial inputs are.
- R8: The value accumulates across separate transfers until a clear. A byte stream split into any mix of beat widths, with idle gaps in between, gives the same result as the unsplit stream.
- R9: When `crc_clear` and `beat_valid` are high in the same cycle, the clear wins and the beat is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_clear | input | 1 | One-cycle command that returns the checksum to all ones |
| beat_valid | input | 1 | Qualifies `beat_data` for one update |
| beat_data | input | DATA_W | Data beat, lowest byte consumed first |
| beat_width | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| poly_sel | input | 2 | 0 0x04C11DB7, 1 0x1EDC6F41, 2 0x1021 (16-bit), 3 same as 0 |
| crc_value | output | 32 | Running checksum |

## Verification
The nine ASCII digits are fed under each polynomial and compared against published check values. These runs separate the three feedback polynomials and the 16-bit narrowing. The same digits are then sent as a word, a halfword and bytes with idle gaps, carrying junk on invalid cycles. This distinguishes lane order, upper-lane masking and carry-over from a value that restarts or drifts. A long run of random widths and selects, including codes 3, is compared each cycle against a model built in the mirrored, right-shifting form. Clears that coincide with a valid beat show whether the clear takes priority.

// File: rtl/crc_accum_pkg.sv
package crc_accum_pkg;

    localparam int CRC_W    = 32;
    localparam int NARROW_W = 16;
    localparam int LANE_W   = 8;

    localparam logic [CRC_W-1:0] CRC_INIT   = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] GEN_ETH    = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] GEN_CAST   = 32'h1EDC_6F41;
    localparam logic [CRC_W-1:0] GEN_NARROW = 32'h0000_1021;

    typedef enum logic [1:0] {
        BEAT_B8   = 2'd0,
        BEAT_B16  = 2'd1,
        BEAT_B32  = 2'd2,
        BEAT_B32X = 2'd3
    } beat_width_e;

    typedef enum logic [1:0] {
        POLY_ETH    = 2'd0,
        POLY_CAST   = 2'd1,
        POLY_NARROW = 2'd2,
        POLY_SPARE  = 2'd3
    } poly_code_e;

    typedef struct packed {
        logic [CRC_W-1:0] gen;
        logic             narrow;
    } poly_cfg_t;

    function automatic poly_cfg_t decode_poly(input poly_code_e code);
        poly_cfg_t cfg;
        case (code)
            POLY_CAST:   begin cfg.gen = GEN_CAST;   cfg.narrow = 1'b0; end
            POLY_NARROW: begin cfg.gen = GEN_NARROW; cfg.narrow = 1'b1; end
            default:     begin cfg.gen = GEN_ETH;    cfg.narrow = 1'b0; end
        endcase
        return cfg;
    endfunction

    // one serial step: MSB-side feedback, register shifts left
    function automatic logic [CRC_W-1:0] bit_step(input logic [CRC_W-1:0] s,
                                                  input logic d,
                                                  input poly_cfg_t cfg);
        logic                fb;
        logic [NARROW_W-1:0] lo;
        logic [CRC_W-1:0]    r;
        if (cfg.narrow) begin
            fb = s[NARROW_W-1] ^ d;
            lo = {s[NARROW_W-2:0], 1'b0} ^ (fb ? cfg.gen[NARROW_W-1:0] : '0);
            r  = {s[CRC_W-1:NARROW_W], lo};
        end else begin
            fb = s[CRC_W-1] ^ d;
            r  = {s[CRC_W-2:0], 1'b0} ^ (fb ? cfg.gen : '0);
        end
        return r;
    endfunction

    // a lane is consumed from its bit 0 upward
    function automatic logic [CRC_W-1:0] lane_step(input logic [CRC_W-1:0] s,
                                                   input logic [LANE_W-1:0] lane,
                                                   input poly_cfg_t cfg);
        logic [CRC_W-1:0] acc;
        acc = s;
        for (int i = 0; i < LANE_W; i++) begin
            acc = bit_step(acc, lane[i], cfg);
        end
        return acc;
    endfunction

endpackage

// File: rtl/crc_poly_decode.sv
module crc_poly_decode
    import crc_accum_pkg::*;
(
    input  logic [1:0] sel,
    output poly_cfg_t  cfg
);

    always_comb begin
        cfg = decode_poly(poly_code_e'(sel));
    end

endmodule

// File: rtl/crc_beat_update.sv
module crc_beat_update
    import crc_accum_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        width,
    input  poly_cfg_t         cfg,
    output logic [CRC_W-1:0]  crc_out
);

    localparam int NLANES  = DATA_W / LANE_W;
    localparam int CNT_W   = $clog2(NLANES + 1);
    localparam int HALF_LN = (NLANES < 2) ? NLANES : 2;

    logic [CNT_W-1:0]              lanes_active;
    logic [NLANES:0][CRC_W-1:0]    chain;

    always_comb begin
        case (beat_width_e'(width))
            BEAT_B8:  lanes_active = CNT_W'(1);
            BEAT_B16: lanes_active = CNT_W'(HALF_LN);
            default:  lanes_active = CNT_W'(NLANES);
        endcase
    end

    assign chain[0] = crc_in;

    // lowest lane first; lanes past the active count pass through
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign chain[g+1] = (CNT_W'(g) < lanes_active)
                          ? lane_step(chain[g], data[g*LANE_W +: LANE_W], cfg)
                          : chain[g];
    end

    assign crc_out = chain[NLANES];

endmodule

// File: rtl/crc_accum.sv
module crc_accum
    import crc_accum_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              crc_clear,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [1:0]        beat_width,
    input  logic [1:0]        poly_sel,
    output logic [CRC_W-1:0]  crc_value
);

    poly_cfg_t        cfg;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;

    crc_poly_decode u_dec (
        .sel (poly_sel),
        .cfg (cfg)
    );

    crc_beat_update #(.DATA_W(DATA_W)) u_upd (
        .crc_in  (crc_q),
        .data    (beat_data),
        .width   (beat_width),
        .cfg     (cfg),
        .crc_out (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst || crc_clear) begin
            crc_q <= CRC_INIT;
        end else if (beat_valid) begin
            crc_q <= crc_next;
        end
    end

    assign crc_value = crc_q;

    a_r1_clear_to_ones: assert property (@(posedge clk) disable iff (rst)
        crc_clear |=> crc_value == CRC_INIT);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!beat_valid && !crc_clear) |=> $stable(crc_value));

    a_r4_upper_half_kept: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !crc_clear && poly_sel == 2'd2)
        |=> crc_value[CRC_W-1:NARROW_W] == $past(crc_value[CRC_W-1:NARROW_W]));

    a_r9_clear_beats_valid: assert property (@(posedge clk) disable iff (rst)
        (crc_clear && beat_valid) |=> crc_value == CRC_INIT);

endmodule

// File: tb/tb_crc_accum.sv
`timescale 1ns/1ps
module tb_crc_accum;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        crc_clear = 1'b0;
    logic        beat_valid = 1'b0;
    logic [31:0] beat_data = '0;
    logic [1:0]  beat_width = '0;
    logic [1:0]  poly_sel = '0;
    logic [31:0] crc_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] model = 32'hFFFF_FFFF;
    logic [31:0] expq[$];
    string       tagq[$];

    always #10 clk = ~clk;

    crc_accum dut (
        .clk(clk), .rst(rst), .crc_clear(crc_clear), .beat_valid(beat_valid),
        .beat_data(beat_data), .beat_width(beat_width), .poly_sel(poly_sel),
        .crc_value(crc_value)
    );

    function automatic logic [31:0] rev32(input logic [31:0] x);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[i] = x[31-i];
        return y;
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] x);
        logic [15:0] y;
        for (int i = 0; i < 16; i++) y[i] = x[15-i];
        return y;
    endfunction

    // mirrored right-shifting model of the requirements
    function automatic logic [31:0] model_beat(input logic [31:0] m, input logic [31:0] d,
                                               input logic [1:0] w, input logic [1:0] p);
        int nbits;
        logic [31:0] r, rp;
        logic [15:0] r16;
        nbits = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
        if (p == 2'd2) begin
            r16 = rev16(m[15:0]);
            for (int i = 0; i < nbits; i++)
                r16 = (r16 >> 1) ^ ((r16[0] ^ d[i]) ? 16'h8408 : 16'h0);
            return {m[31:16], rev16(r16)};
        end
        rp = (p == 2'd1) ? rev32(32'h1EDC6F41) : rev32(32'h04C11DB7);
        r  = rev32(m);
        for (int i = 0; i < nbits; i++)
            r = (r >> 1) ^ ((r[0] ^ d[i]) ? rp : 32'h0);
        return rev32(r);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic v, input logic c,
                         input logic [31:0] d, input logic [1:0] w, input logic [1:0] p);
        @(negedge clk);
        beat_valid = v; crc_clear = c; beat_data = d; beat_width = w; poly_sel = p;
        if (c) model = 32'hFFFF_FFFF;
        else if (v) model = model_beat(model, d, w, p);
        expq.push_back(model);
        tagq.push_back(tag);
    endtask

    task automatic settle_and_check(input string tag, input logic [31:0] exp);
        drive(tag, 1'b0, 1'b0, 32'hDEAD_BEEF, 2'd2, 2'd1);
        wait (expq.size() == 0);
        #1;
        check(tag, crc_value, exp);
    endtask

    task automatic digits_bytes(input string tag, input logic [1:0] p);
        for (int i = 0; i < 9; i++)
            drive(tag, 1'b1, 1'b0, {24'hA5A5A5, 8'h31 + 8'(i)}, 2'd0, p);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (expq.size() > 0) check(tagq.pop_front(), crc_value, expq.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive("R1 reset value", 1'b0, 1'b0, 32'h1234_5678, 2'd0, 2'd0);

        digits_bytes("R2 byte beats poly0", 2'd0);
        settle_and_check("R2 check value", rev32(32'hCBF43926) ^ 32'hFFFF_FFFF);

        drive("R1 clear", 1'b0, 1'b1, '0, 2'd0, 2'd0);
        drive("R6 word lanes", 1'b1, 1'b0, 32'h3433_3231, 2'd2, 2'd0);
        drive("R7 idle junk", 1'b0, 1'b0, 32'hFFFF_0000, 2'd0, 2'd2);
        drive("R6 half lanes", 1'b1, 1'b0, 32'hC3C3_3635, 2'd1, 2'd0);
        drive("R7 idle junk", 1'b0, 1'b0, 32'h0F0F_0F0F, 2'd2, 2'd1);
        drive("R8 byte tail", 1'b1, 1'b0, 32'h7777_7737, 2'd0, 2'd0);
        drive("R8 byte tail", 1'b1, 1'b0, 32'h0000_0038, 2'd0, 2'd0);
        drive("R8 byte tail", 1'b1, 1'b0, 32'hFFFF_FF39, 2'd0, 2'd0);
        settle_and_check("R8 split stream", rev32(32'hCBF43926) ^ 32'hFFFF_FFFF);

        drive("R1 clear", 1'b0, 1'b1, '0, 2'd0, 2'd0);
        digits_bytes("R3 byte beats poly1", 2'd1);
        settle_and_check("R3 check value", rev32(32'hE3069283) ^ 32'hFFFF_FFFF);

        drive("R1 clear", 1'b0, 1'b1, '0, 2'd0, 2'd0);
        digits_bytes("R4 byte beats poly2", 2'd2);
        settle_and_check("R4 check value", {16'hFFFF, rev16(16'h6F91)});

        drive("R1 clear", 1'b0, 1'b1, '0, 2'd0, 2'd0);
        drive("R5 code3 word", 1'b1, 1'b0, 32'h3433_3231, 2'd3, 2'd3);
        drive("R5 code3 half", 1'b1, 1'b0, 32'h0000_3635, 2'd1, 2'd3);
        drive("R5 code3 byte", 1'b1, 1'b0, 32'h0000_0037, 2'd0, 2'd3);
        drive("R5 code3 byte", 1'b1, 1'b0, 32'h0000_0038, 2'd0, 2'd3);
        drive("R5 code3 byte", 1'b1, 1'b0, 32'h0000_0039, 2'd0, 2'd3);
        settle_and_check("R5 code3 as code0", rev32(32'hCBF43926) ^ 32'hFFFF_FFFF);

        drive("R6 beat before clear", 1'b1, 1'b0, 32'hCAFE_F00D, 2'd2, 2'd1);
        drive("R9 clear with valid", 1'b1, 1'b1, 32'h5555_AAAA, 2'd2, 2'd0);

        for (int k = 0; k < 400; k++) begin
            logic [31:0] d;
            logic [1:0]  w, p;
            logic        v, c;
            d = $urandom; w = 2'($urandom); p = 2'($urandom);
            v = ($urandom % 4) != 0;
            c = ($urandom % 40) == 0;
            drive(c ? "R9 random clear" : (v ? "R6 random beat" : "R7 random idle"), v, c, d, w, p);
        end

        wait (expq.size() == 0);
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule